// File: doc/BRIEF.md
# Output Channel Selector

This block sits between the input-side packet controller of a one-to-three packet switch and the three output queues that feed the switch's output ports. When the controller flags the header byte, the block records the two-bit destination carried in the low bits of that byte and keeps it until the next header. The recorded destination then decides two things. It picks which queue's full and empty flags are reported back to the controller. It also picks which single queue receives the controller's write strobe.

Destination codes 0, 1 and 2 name the three queues. Code 3 names no queue. For code 3 the block reports a queue that is full and not empty, so the controller never starts loading, and no queue is written. In the header cycle itself the flags are selected from the incoming destination rather than the stored one, so the controller can decide what to do in that same cycle. Each port's ready indication to its downstream reader is the inverse of that queue's empty flag.

All pins are plain control and status levels; there is no data path and no handshake at the block's edge.

Top module: `chan_select`

## Requirements
- R1: A synchronous reset (rst_n low at a rising clock edge) clears the stored destination to 0, and this takes priority over a header capture in the same cycle. After reset the flags and the write strobe are routed to queue 0.
- R2: The stored destination is loaded from hdr_dest at a rising edge where hdr_strobe is high. Otherwise it holds, whatever hdr_dest does.
- R3: With a stored or incoming destination of 0, 1 or 2, sel_full equals q_full[dest] and sel_empty equals q_empty[dest] (bit n of each vector belongs to queue n).
- R4: With destination 3, sel_full is 1 and sel_empty is 0, whatever the queue flags are.
- R5: While hdr_strobe is high, the flag selection uses hdr_dest combinationally in that cycle. While it is low, the selection uses the stored destination.
- R6: port_ready[n] is the inverse of q_empty[n] for every queue, combinationally.
- R7: q_wr_en[n] equals wr_req when the stored destination is n, and is 0 otherwise, so q_wr_en is always one-hot or zero.
- R8: When the stored destination is 3, q_wr_en is all zero even with wr_req high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_strobe | input | 1 | High in the header cycle; capture the destination |
| hdr_dest | input | 2 | Destination field of the incoming header byte |
| wr_req | input | 1 | Write strobe from the controller |
| q_full | input | 3 | Full flag of each queue, bit n is queue n |
| q_empty | input | 3 | Empty flag of each queue, bit n is queue n |
| sel_full | output | 1 | Full flag of the selected queue (1 for destination 3) |
| sel_empty | output | 1 | Empty flag of the selected queue (0 for destination 3) |
| q_wr_en | output | 3 | Write enable for each queue, one-hot or zero |
| port_ready | output | 3 | Data-available indication for each port's reader |

## Verification
Two functions can act in the same cycle: the header capture that loads a new destination, and the flag report that the controller reads in that cycle, which must already reflect the new destination and not the stored one. The bench stores one destination, then raises hdr_strobe with a different destination and with flag patterns that differ between the two queues. It samples sel_full and sel_empty before the capturing edge and expects the incoming queue's flags, then checks after the edge that the write strobe has moved to the new queue. A reset that coincides with a header strobe is also driven, and the result must be queue 0.

// File: rtl/chan_select_pkg.sv
package chan_select_pkg;
  localparam int unsigned PORTS  = 3;
  localparam int unsigned DEST_W = 2;
  typedef logic [DEST_W-1:0] dest_t;
endpackage

// File: rtl/dest_latch.sv
module dest_latch #(
  parameter int unsigned DEST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [DEST_W-1:0] dest_in,
  output logic [DEST_W-1:0] dest_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)       dest_q <= '0;
    else if (capture) dest_q <= dest_in;
  end
endmodule

// File: rtl/flag_select.sv
module flag_select #(
  parameter int unsigned PORTS  = 3,
  parameter int unsigned DEST_W = 2
) (
  input  logic [DEST_W-1:0] sel,
  input  logic [PORTS-1:0]  full_vec,
  input  logic [PORTS-1:0]  empty_vec,
  output logic              full_o,
  output logic              empty_o
);
  // Out-of-range codes look like a blocked queue: full, not empty.
  always_comb begin
    full_o  = 1'b1;
    empty_o = 1'b0;
    for (int i = 0; i < int'(PORTS); i++) begin
      if (sel == DEST_W'(i)) begin
        full_o  = full_vec[i];
        empty_o = empty_vec[i];
      end
    end
  end
endmodule

// File: rtl/write_steer.sv
module write_steer #(
  parameter int unsigned PORTS  = 3,
  parameter int unsigned DEST_W = 2
) (
  input  logic [DEST_W-1:0] sel,
  input  logic              req,
  output logic [PORTS-1:0]  en_vec
);
  for (genvar g = 0; g < int'(PORTS); g++) begin : g_port
    assign en_vec[g] = req && (sel == DEST_W'(g));
  end
endmodule

// File: rtl/chan_select.sv
module chan_select
  import chan_select_pkg::*;
#(
  parameter int unsigned NPORT = PORTS,
  parameter int unsigned DW    = DEST_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hdr_strobe,
  input  logic [DW-1:0]    hdr_dest,
  input  logic             wr_req,
  input  logic [NPORT-1:0] q_full,
  input  logic [NPORT-1:0] q_empty,
  output logic             sel_full,
  output logic             sel_empty,
  output logic [NPORT-1:0] q_wr_en,
  output logic [NPORT-1:0] port_ready
);
  logic [DW-1:0] dest_q;
  logic [DW-1:0] flag_sel;

  dest_latch #(.DEST_W(DW)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (hdr_strobe),
    .dest_in (hdr_dest),
    .dest_q  (dest_q)
  );

  // Header cycle bypasses the register so the controller decides at once.
  assign flag_sel = hdr_strobe ? hdr_dest : dest_q;

  flag_select #(.PORTS(NPORT), .DEST_W(DW)) u_flags (
    .sel       (flag_sel),
    .full_vec  (q_full),
    .empty_vec (q_empty),
    .full_o    (sel_full),
    .empty_o   (sel_empty)
  );

  write_steer #(.PORTS(NPORT), .DEST_W(DW)) u_steer (
    .sel    (dest_q),
    .req    (wr_req),
    .en_vec (q_wr_en)
  );

  for (genvar g = 0; g < int'(NPORT); g++) begin : g_ready
    assign port_ready[g] = ~q_empty[g];
  end
endmodule

// File: rtl/chan_select_chk.sv
module chan_select_chk #(
  parameter int unsigned NPORT = 3,
  parameter int unsigned DW    = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hdr_strobe,
  input logic [DW-1:0]    hdr_dest,
  input logic             wr_req,
  input logic [NPORT-1:0] q_full,
  input logic [NPORT-1:0] q_empty,
  input logic             sel_full,
  input logic             sel_empty,
  input logic [NPORT-1:0] q_wr_en,
  input logic [NPORT-1:0] port_ready
);
  AST_WR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(q_wr_en)); // R7
  AST_WR_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n) !wr_req |-> q_wr_en == '0); // R7
  AST_BAD_DEST_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_strobe && hdr_dest == DW'(3)) |-> (sel_full && !sel_empty)); // R4
  AST_BAD_DEST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!hdr_strobe && $past(rst_n) && $past(hdr_strobe) && $past(hdr_dest) == DW'(3)) |-> q_wr_en == '0); // R8
  AST_STEER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(hdr_strobe) && wr_req && $past(wr_req)) |-> q_wr_en == $past(q_wr_en)); // R2
  AST_READY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(port_ready) == $countones(~q_empty)); // R6
endmodule

bind chan_select chan_select_chk #(.NPORT(NPORT), .DW(DW)) u_chk (.*);

// File: tb/chan_select_test.sv
`timescale 1ns/1ps
module chan_select_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hdr_strobe = 1'b0;
  logic [1:0] hdr_dest = 2'd0;
  logic       wr_req = 1'b0;
  logic [2:0] q_full = 3'b000;
  logic [2:0] q_empty = 3'b111;
  logic       sel_full, sel_empty;
  logic [2:0] q_wr_en, port_ready;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  chan_select uut (
    .clk(clk), .rst_n(rst_n), .hdr_strobe(hdr_strobe), .hdr_dest(hdr_dest),
    .wr_req(wr_req), .q_full(q_full), .q_empty(q_empty),
    .sel_full(sel_full), .sel_empty(sel_empty),
    .q_wr_en(q_wr_en), .port_ready(port_ready)
  );

  task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Capture a destination: strobe in one cycle, release after the edge.
  task automatic load_dest(input logic [1:0] d);
    @(negedge clk);
    hdr_strobe = 1'b1; hdr_dest = d;
    @(negedge clk);
    hdr_strobe = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    wr_req = 1'b1; q_full = 3'b001; q_empty = 3'b110; #2;
    check("R1 write after reset", q_wr_en, 3'b001);
    check("R1 full after reset", {2'b0, sel_full}, 3'b001);
    check("R1 empty after reset", {2'b0, sel_empty}, 3'b000);
    wr_req = 1'b0;
  endtask

  task automatic t_steer();
    for (int p = 0; p < 3; p++) begin
      load_dest(2'(p));
      wr_req = 1'b1; #2;
      check("R7 steer to latched port", q_wr_en, 3'(1 << p));
      wr_req = 1'b0; #2;
      check("R7 no request no write", q_wr_en, 3'b000);
    end
  endtask

  task automatic t_select();
    for (int p = 0; p < 3; p++) begin
      load_dest(2'(p));
      q_full = 3'(1 << p); q_empty = ~3'(1 << p); #2;
      check("R3 full picked", {2'b0, sel_full}, 3'b001);
      check("R3 empty picked", {2'b0, sel_empty}, 3'b000);
      q_full = ~3'(1 << p); q_empty = 3'(1 << p); #2;
      check("R3 full picked inv", {2'b0, sel_full}, 3'b000);
      check("R3 empty picked inv", {2'b0, sel_empty}, 3'b001);
    end
  endtask

  task automatic t_invalid();
    @(negedge clk);
    q_full = 3'b000; q_empty = 3'b111;
    hdr_strobe = 1'b1; hdr_dest = 2'd3; #2;
    check("R4 bad dest full in header cycle", {2'b0, sel_full}, 3'b001);
    check("R4 bad dest empty in header cycle", {2'b0, sel_empty}, 3'b000);
    @(negedge clk);
    hdr_strobe = 1'b0; wr_req = 1'b1; #2;
    check("R8 no write to bad dest", q_wr_en, 3'b000);
    check("R4 bad dest full stored", {2'b0, sel_full}, 3'b001);
    check("R4 bad dest empty stored", {2'b0, sel_empty}, 3'b000);
    wr_req = 1'b0;
  endtask

  task automatic t_bypass();
    load_dest(2'd0);
    q_full = 3'b100; q_empty = 3'b011; #2;
    check("R5 stored dest used when idle", {sel_full, sel_empty, 1'b0}, 3'b010);
    @(negedge clk);
    hdr_strobe = 1'b1; hdr_dest = 2'd2; wr_req = 1'b1; #2;
    check("R5 incoming dest used in header cycle", {sel_full, sel_empty, 1'b0}, 3'b100);
    check("R7 write still on old dest before edge", q_wr_en, 3'b001);
    @(negedge clk);
    hdr_strobe = 1'b0; #2;
    check("R2 write moved after capture", q_wr_en, 3'b100);
    wr_req = 1'b0;
  endtask

  task automatic t_hold();
    load_dest(2'd1);
    wr_req = 1'b1; q_full = 3'b010; q_empty = 3'b101;
    for (int k = 0; k < 4; k++) begin
      hdr_dest = 2'(k);
      @(negedge clk); #2;
      check("R2 dest held write", q_wr_en, 3'b010);
      check("R2 dest held flags", {sel_full, sel_empty, 1'b0}, 3'b100);
    end
    wr_req = 1'b0;
  endtask

  task automatic t_ready();
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      q_empty = 3'(v); #2;
      check("R6 ready is not empty", port_ready, ~3'(v));
    end
  endtask

  task automatic t_reset_vs_capture();
    load_dest(2'd2);
    @(negedge clk);
    rst_n = 1'b0; hdr_strobe = 1'b1; hdr_dest = 2'd1;
    @(negedge clk);
    rst_n = 1'b1; hdr_strobe = 1'b0; wr_req = 1'b1; #2;
    check("R1 reset beats capture", q_wr_en, 3'b001);
    wr_req = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_steer();
    t_select();
    t_invalid();
    t_bypass();
    t_hold();
    t_ready();
    t_reset_vs_capture();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule